// File: doc/BRIEF.md
# Outstanding Cache Request Tracker

This block sits between a processor port and its first-level cache controller. It keeps a record of every memory request that has been issued and has not yet completed. Reads and writes are held in two separate tables, and each entry is keyed by the cache line the request touches. When a new request arrives, the block decides in the same cycle whether to accept it, to reject it because the line is already busy, to reject it because the tracker is at capacity, or to reject it as a request type it cannot handle.

Each incoming request is sorted into two types. The primary type sets which table tracks the request. The secondary type travels with the request to the cache controller. Accepted requests appear on a registered issue output one cycle later. Completions name a line and a table, and they free the matching entry. Four saturating-free wrap counters record the aliasing stalls, one for each pairing of the new request's class with the class of the entry that blocked it. A watchdog compares each entry's age against a threshold. The first time any entry is too old, the watchdog latches an error, together with that entry's line and primary type.

Top module: `req_tracker`

## Requirements
- R1: A request is refused with status 2 (full) when the outstanding count, less any entry freed by a completion in the same cycle, is at least MAX_OUT.
- R2: Two addresses refer to the same line when they agree above the low log2(LINE_BYTES) bits. The line reported by the watchdog has those low bits cleared.
- R3: The primary type selects the table. Store (2), RMW read (3), RMW write (4), load-linked (5), store-conditional (6), locked read (7), locked write (8) and flush (9) go to the write table. Load (0) and instruction fetch (1) go to the read table.
- R4: The request is classified from the op code (0 read, 1 write, 2 flush) and from the flags, and the secondary type is issued as follows:
  - An LL/SC write is store-conditional and an LL/SC read is load-linked. Both issue as atomic (10).
  - A locked write or read is a locked RMW write or read. Both issue as store (2).
  - A read with the fetch flag is an instruction fetch (1).
  - A read with the store-check flag is an RMW read that issues as store (2).
  - Any other read is a load (0), a plain write is a store (2), and a flush is a flush (9).
- R5: A request whose line is held in either table is refused with status 1 (aliased).
- R6: An aliased refusal increments exactly one stall counter. The counter is chosen by the new request's class and by which table blocked it, and the read table is blamed first for a write-class request.
- R7: Op code 3, or a flush combined with the LL/SC or locked flag, is refused with status 3 (unsupported) and changes no table.
- R8: The watchdog latches a sticky error when an entry's age reaches DL_THRESH cycles. The error appears within two cycles of that point and reports the entry's line and primary type.
- R9: A completion removes the matching entry from the table it names and decrements the count. A completion that matches no entry has no effect. The count always equals the sum of the two table occupancies.
- R10: Only an accepted request (status 0) raises iss_valid, one cycle later, with its full address and secondary type.
- R11: A completion that arrives in the same cycle as a request frees its slot first, so a request arriving at full capacity is accepted.
- R12: Reset clears both tables, the count, the stall counters, the issue output and the deadlock error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 flush, 3 other |
| req_llsc | input | 1 | Load-linked / store-conditional flag |
| req_locked | input | 1 | Locked read-modify-write flag |
| req_ifetch | input | 1 | Instruction fetch flag |
| req_store_chk | input | 1 | Read that must obtain write permission |
| req_addr | input | AW | Request byte address |
| req_status | output | 2 | 0 accept, 1 aliased, 2 full, 3 unsupported (same cycle) |
| cpl_valid | input | 1 | Completion strobe |
| cpl_write | input | 1 | Completion targets the write table |
| cpl_line | input | AW-log2(LINE_BYTES) | Line number of the completion |
| iss_valid | output | 1 | Registered issue strobe |
| iss_addr | output | AW | Issued address |
| iss_kind | output | 4 | Issued secondary type |
| outstanding | output | log2(MAX_OUT+1) | Entries held |
| stall_st_ld | output | CW | Write-class blocked by read entry |
| stall_st_st | output | CW | Write-class blocked by write entry |
| stall_ld_st | output | CW | Read-class blocked by write entry |
| stall_ld_ld | output | CW | Read-class blocked by read entry |
| dl_err | output | 1 | Sticky deadlock error |
| dl_line | output | AW | Line address of the stale entry |
| dl_kind | output | 4 | Primary type of the stale entry |

## Verification
The stimulus walks loads, stores, LL/SC, locked, store-check, fetch and flush requests across a handful of lines. These include addresses inside an already busy line, so that every pairing of request class and blocking table appears once and the four stall counters can be told apart. The tracker is filled to capacity to separate the full status from the aliased one. A completion and a request are then driven in the same cycle to show that the freed slot is reused. Completions to an empty line, or to the wrong table, show that nothing changes. A final run holds one load past the watchdog threshold and checks the reported line.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [3:0] {
    K_LOAD   = 4'd0,
    K_IFETCH = 4'd1,
    K_STORE  = 4'd2,
    K_RMW_RD = 4'd3,
    K_RMW_WR = 4'd4,
    K_LL     = 4'd5,
    K_SC     = 4'd6,
    K_LK_RD  = 4'd7,
    K_LK_WR  = 4'd8,
    K_FLUSH  = 4'd9,
    K_ATOMIC = 4'd10,
    K_NONE   = 4'd15
  } kind_e;

  typedef enum logic [1:0] {
    ST_ACCEPT = 2'd0,
    ST_ALIAS  = 2'd1,
    ST_FULL   = 2'd2,
    ST_UNSUP  = 2'd3
  } status_e;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_FLUSH = 2'd2;

  function automatic logic is_write_class(input kind_e k);
    return (k == K_STORE) || (k == K_RMW_RD) || (k == K_RMW_WR) ||
           (k == K_LL) || (k == K_SC) || (k == K_LK_RD) ||
           (k == K_LK_WR) || (k == K_FLUSH);
  endfunction
endpackage

// File: rtl/trk_classify.sv
module trk_classify
  import trk_pkg::*;
(
  input  logic [1:0] op,
  input  logic       llsc,
  input  logic       locked,
  input  logic       ifetch,
  input  logic       store_chk,
  output kind_e      prim,
  output kind_e      sec,
  output logic       unsup
);
  always_comb begin
    prim  = K_NONE;
    sec   = K_NONE;
    unsup = 1'b0;
    if (llsc) begin
      sec = K_ATOMIC;
      if (op == OP_WRITE)     prim = K_SC;
      else if (op == OP_READ) prim = K_LL;
      else                    unsup = 1'b1;
    end else if (locked) begin
      sec = K_STORE;
      if (op == OP_WRITE)     prim = K_LK_WR;
      else if (op == OP_READ) prim = K_LK_RD;
      else                    unsup = 1'b1;
    end else begin
      case (op)
        OP_READ: begin
          if (ifetch) begin
            prim = K_IFETCH; sec = K_IFETCH;
          end else if (store_chk) begin
            prim = K_RMW_RD; sec = K_STORE;
          end else begin
            prim = K_LOAD; sec = K_LOAD;
          end
        end
        OP_WRITE: begin prim = K_STORE; sec = K_STORE; end
        OP_FLUSH: begin prim = K_FLUSH; sec = K_FLUSH; end
        default:  unsup = 1'b1;
      endcase
    end
    if (unsup) begin
      prim = K_NONE;
      sec  = K_NONE;
    end
  end
endmodule

// File: rtl/trk_line_cam.sv
module trk_line_cam
  import trk_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int TAGW   = 10,
  parameter int TSW    = 16,
  parameter int THRESH = 256,
  localparam int OCCW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TSW-1:0]  now,
  input  logic [TAGW-1:0] lk_tag,
  output logic            lk_hit,
  input  logic            del_en,
  input  logic [TAGW-1:0] del_tag,
  output logic            del_hit,
  input  logic            ins_en,
  input  logic [TAGW-1:0] ins_tag,
  input  kind_e           ins_kind,
  output logic [OCCW-1:0] occ,
  output logic            stale,
  output logic [TAGW-1:0] stale_tag,
  output kind_e           stale_kind
);
  localparam logic [TSW-1:0] TH_T = TSW'(THRESH);

  logic [DEPTH-1:0] valid;
  logic [TAGW-1:0]  tag_q  [DEPTH];
  kind_e            kind_q [DEPTH];
  logic [TSW-1:0]   ts_q   [DEPTH];

  logic [DEPTH-1:0] m_lk, m_del, ins_oh;

  always_comb begin
    logic found;
    logic [TSW-1:0] age;
    found      = 1'b0;
    ins_oh     = '0;
    stale      = 1'b0;
    stale_tag  = '0;
    stale_kind = K_NONE;
    occ        = '0;
    for (int i = 0; i < DEPTH; i++) begin
      m_lk[i]  = valid[i] && (tag_q[i] == lk_tag);
      m_del[i] = del_en && valid[i] && (tag_q[i] == del_tag);
      if ((!valid[i] || m_del[i]) && !found) begin
        ins_oh[i] = 1'b1;
        found     = 1'b1;
      end
      occ = occ + OCCW'(valid[i]);
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      age = now - ts_q[i];
      if (valid[i] && (age >= TH_T)) begin
        stale      = 1'b1;
        stale_tag  = tag_q[i];
        stale_kind = kind_q[i];
      end
    end
    lk_hit  = |(m_lk & ~m_del);
    del_hit = |m_del;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        valid[g]  <= 1'b0;
        tag_q[g]  <= '0;
        kind_q[g] <= K_NONE;
        ts_q[g]   <= '0;
      end else if (ins_en && ins_oh[g]) begin
        valid[g]  <= 1'b1;
        tag_q[g]  <= ins_tag;
        kind_q[g] <= ins_kind;
        ts_q[g]   <= now;
      end else if (m_del[g]) begin
        valid[g]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trk_deadlock.sv
module trk_deadlock
  import trk_pkg::*;
#(
  parameter int TAGW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stale_a,
  input  logic [TAGW-1:0] tag_a,
  input  kind_e           kind_a,
  input  logic            stale_b,
  input  logic [TAGW-1:0] tag_b,
  input  kind_e           kind_b,
  output logic            err,
  output logic [TAGW-1:0] err_tag,
  output kind_e           err_kind
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err      <= 1'b0;
      err_tag  <= '0;
      err_kind <= K_NONE;
    end else if (!err && (stale_a || stale_b)) begin
      err      <= 1'b1;
      err_tag  <= stale_a ? tag_a : tag_b;
      err_kind <= stale_a ? kind_a : kind_b;
    end
  end
endmodule

// File: rtl/req_tracker.sv
module req_tracker
  import trk_pkg::*;
#(
  parameter int AW         = 16,
  parameter int LINE_BYTES = 64,
  parameter int MAX_OUT    = 4,
  parameter int DL_THRESH  = 256,
  parameter int TSW        = 16,
  parameter int CW         = 16,
  localparam int OFFW      = $clog2(LINE_BYTES),
  localparam int TAGW      = AW - OFFW,
  localparam int CNTW      = $clog2(MAX_OUT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic            req_llsc,
  input  logic            req_locked,
  input  logic            req_ifetch,
  input  logic            req_store_chk,
  input  logic [AW-1:0]   req_addr,
  output logic [1:0]      req_status,
  input  logic            cpl_valid,
  input  logic            cpl_write,
  input  logic [TAGW-1:0] cpl_line,
  output logic            iss_valid,
  output logic [AW-1:0]   iss_addr,
  output logic [3:0]      iss_kind,
  output logic [CNTW-1:0] outstanding,
  output logic [CW-1:0]   stall_st_ld,
  output logic [CW-1:0]   stall_st_st,
  output logic [CW-1:0]   stall_ld_st,
  output logic [CW-1:0]   stall_ld_ld,
  output logic            dl_err,
  output logic [AW-1:0]   dl_line,
  output logic [3:0]      dl_kind
);
  kind_e prim, sec;
  logic  unsup, wclass, acc;
  status_e st;
  logic [TAGW-1:0] req_tag;
  logic [TSW-1:0]  now;
  logic rd_hit, wr_hit, rd_del, wr_del, cpl_hit;
  logic [CNTW-1:0] rd_occ, wr_occ, eff_cnt;
  logic rd_stale, wr_stale;
  logic [TAGW-1:0] rd_stale_tag, wr_stale_tag, err_tag;
  kind_e rd_stale_kind, wr_stale_kind, err_kind;

  assign req_tag = req_addr[AW-1:OFFW];

  trk_classify u_cls (
    .op(req_op), .llsc(req_llsc), .locked(req_locked), .ifetch(req_ifetch),
    .store_chk(req_store_chk), .prim(prim), .sec(sec), .unsup(unsup)
  );

  assign wclass  = is_write_class(prim);
  assign cpl_hit = rd_del | wr_del;
  assign eff_cnt = outstanding - CNTW'(cpl_hit);

  always_comb begin
    if (eff_cnt >= CNTW'(MAX_OUT)) st = ST_FULL;
    else if (unsup)                st = ST_UNSUP;
    else if (rd_hit || wr_hit)     st = ST_ALIAS;
    else                           st = ST_ACCEPT;
  end
  assign req_status = st;
  assign acc = req_valid && (st == ST_ACCEPT);

  trk_line_cam #(.DEPTH(MAX_OUT), .TAGW(TAGW), .TSW(TSW), .THRESH(DL_THRESH)) u_rd (
    .clk(clk), .rst(rst), .now(now), .lk_tag(req_tag), .lk_hit(rd_hit),
    .del_en(cpl_valid && !cpl_write), .del_tag(cpl_line), .del_hit(rd_del),
    .ins_en(acc && !wclass), .ins_tag(req_tag), .ins_kind(prim), .occ(rd_occ),
    .stale(rd_stale), .stale_tag(rd_stale_tag), .stale_kind(rd_stale_kind)
  );

  trk_line_cam #(.DEPTH(MAX_OUT), .TAGW(TAGW), .TSW(TSW), .THRESH(DL_THRESH)) u_wr (
    .clk(clk), .rst(rst), .now(now), .lk_tag(req_tag), .lk_hit(wr_hit),
    .del_en(cpl_valid && cpl_write), .del_tag(cpl_line), .del_hit(wr_del),
    .ins_en(acc && wclass), .ins_tag(req_tag), .ins_kind(prim), .occ(wr_occ),
    .stale(wr_stale), .stale_tag(wr_stale_tag), .stale_kind(wr_stale_kind)
  );

  trk_deadlock #(.TAGW(TAGW)) u_dl (
    .clk(clk), .rst(rst),
    .stale_a(rd_stale), .tag_a(rd_stale_tag), .kind_a(rd_stale_kind),
    .stale_b(wr_stale), .tag_b(wr_stale_tag), .kind_b(wr_stale_kind),
    .err(dl_err), .err_tag(err_tag), .err_kind(err_kind)
  );
  assign dl_line = {err_tag, {OFFW{1'b0}}};
  assign dl_kind = err_kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      now         <= '0;
      outstanding <= '0;
      iss_valid   <= 1'b0;
      iss_addr    <= '0;
      iss_kind    <= K_NONE;
      stall_st_ld <= '0;
      stall_st_st <= '0;
      stall_ld_st <= '0;
      stall_ld_ld <= '0;
    end else begin
      now         <= now + 1'b1;
      outstanding <= outstanding + CNTW'(acc) - CNTW'(cpl_hit);
      iss_valid   <= acc;
      if (acc) begin
        iss_addr <= req_addr;
        iss_kind <= sec;
      end
      if (req_valid && (st == ST_ALIAS)) begin
        if (wclass) begin
          if (rd_hit) stall_st_ld <= stall_st_ld + 1'b1;
          else        stall_st_st <= stall_st_st + 1'b1;
        end else begin
          if (wr_hit) stall_ld_st <= stall_ld_st + 1'b1;
          else        stall_ld_ld <= stall_ld_ld + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trk_checker.sv
module trk_checker #(
  parameter int CNTW    = 3,
  parameter int MAX_OUT = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [1:0]      req_status,
  input logic            cpl_valid,
  input logic            iss_valid,
  input logic [CNTW-1:0] outstanding,
  input logic [CNTW-1:0] rd_occ,
  input logic [CNTW-1:0] wr_occ,
  input logic            dl_err
);
  // R9
  count_sum_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, outstanding} == ({1'b0, rd_occ} + {1'b0, wr_occ}));

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    outstanding <= CNTW'(MAX_OUT));

  // R10
  issue_only_accepted_chk: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> $past(req_valid && (req_status == 2'd0)));

  // R8
  dl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    dl_err |=> dl_err);

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !cpl_valid) |=> $stable(outstanding));
endmodule

bind req_tracker trk_checker #(.CNTW(CNTW), .MAX_OUT(MAX_OUT)) u_trk_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_status(req_status),
  .cpl_valid(cpl_valid), .iss_valid(iss_valid), .outstanding(outstanding),
  .rd_occ(rd_occ), .wr_occ(wr_occ), .dl_err(dl_err)
);

// File: tb/req_tracker_bench.sv
module req_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TB_DL      = 100;
  localparam int AW = 16, OFFW = 6, TAGW = AW - OFFW;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_llsc = 0, req_locked = 0, req_ifetch = 0, req_store_chk = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [1:0] req_status;
  logic cpl_valid = 0, cpl_write = 0;
  logic [TAGW-1:0] cpl_line = 0;
  logic iss_valid, dl_err;
  logic [AW-1:0] iss_addr, dl_line;
  logic [3:0] iss_kind, dl_kind;
  logic [2:0] outstanding;
  logic [15:0] s_st_ld, s_st_st, s_ld_st, s_ld_ld;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  req_tracker #(.DL_THRESH(TB_DL)) u_req_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_llsc(req_llsc), .req_locked(req_locked), .req_ifetch(req_ifetch),
    .req_store_chk(req_store_chk), .req_addr(req_addr), .req_status(req_status),
    .cpl_valid(cpl_valid), .cpl_write(cpl_write), .cpl_line(cpl_line),
    .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_kind(iss_kind),
    .outstanding(outstanding), .stall_st_ld(s_st_ld), .stall_st_st(s_st_st),
    .stall_ld_st(s_ld_st), .stall_ld_ld(s_ld_ld), .dl_err(dl_err),
    .dl_line(dl_line), .dl_kind(dl_kind)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // vector: kind(0 req,1 cpl rd,2 cpl wr), op, flags{llsc,locked,ifetch,stchk}, addr, status, sec kind, count
  localparam int NV = 15;
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 2'd0, 4'b0000, 16'h0100, 2'd0, 4'd0,  3'd1},
    {2'd0, 2'd0, 4'b0000, 16'h0104, 2'd1, 4'd0,  3'd1},
    {2'd0, 2'd1, 4'b0000, 16'h0120, 2'd1, 4'd0,  3'd1},
    {2'd0, 2'd1, 4'b0000, 16'h0200, 2'd0, 4'd2,  3'd2},
    {2'd0, 2'd0, 4'b0000, 16'h0210, 2'd1, 4'd0,  3'd2},
    {2'd0, 2'd1, 4'b1000, 16'h0300, 2'd0, 4'd10, 3'd3},
    {2'd0, 2'd0, 4'b0010, 16'h0400, 2'd0, 4'd1,  3'd4},
    {2'd0, 2'd0, 4'b0000, 16'h0500, 2'd2, 4'd0,  3'd4},
    {2'd2, 2'd0, 4'b0000, 16'h0200, 2'd0, 4'd0,  3'd3},
    {2'd0, 2'd0, 4'b0001, 16'h0600, 2'd0, 4'd2,  3'd4},
    {2'd1, 2'd0, 4'b0000, 16'h0100, 2'd0, 4'd0,  3'd3},
    {2'd1, 2'd0, 4'b0000, 16'h0100, 2'd0, 4'd0,  3'd3},
    {2'd0, 2'd1, 4'b0000, 16'h0610, 2'd1, 4'd0,  3'd3},
    {2'd0, 2'd3, 4'b0000, 16'h0a00, 2'd3, 4'd0,  3'd3},
    {2'd0, 2'd0, 4'b0100, 16'h0700, 2'd0, 4'd2,  3'd4}
  };

  // Drives one request or completion for a cycle; st is the same-cycle status.
  task automatic step(input logic [1:0] kind, input logic [1:0] op, input logic [3:0] fl,
                      input logic [15:0] addr, output logic [1:0] st);
    @(negedge clk);
    if (kind == 2'd0) begin
      req_valid = 1; req_op = op; req_addr = addr;
      {req_llsc, req_locked, req_ifetch, req_store_chk} = fl;
    end else begin
      cpl_valid = 1; cpl_write = (kind == 2'd2); cpl_line = addr[AW-1:OFFW];
    end
    #1 st = req_status;
    @(posedge clk);
    #1;
    req_valid = 0; cpl_valid = 0;
    {req_llsc, req_locked, req_ifetch, req_store_chk} = 4'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] st;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R12 reset state
    chk("R12 count", 32'(outstanding), 0);
    chk("R12 issue", 32'(iss_valid), 0);
    chk("R12 dl_err", 32'(dl_err), 0);

    for (int v = 0; v < NV; v++) begin
      logic [32:0] e;
      e = VEC[v];
      step(e[32:31], e[30:29], e[28:25], e[24:9], st);
      if (e[32:31] == 2'd0) begin
        case (e[8:7])
          2'd0: begin // R10 / R4
            chk("R10 status", 32'(st), 0);
            chk("R10 iss_valid", 32'(iss_valid), 1);
            chk("R4 iss_kind", 32'(iss_kind), 32'(e[6:3]));
            chk("R10 iss_addr", 32'(iss_addr), 32'(e[24:9]));
          end
          2'd1: begin chk("R5 aliased", 32'(st), 1); chk("R10 no issue", 32'(iss_valid), 0); end
          2'd2: begin chk("R1 full", 32'(st), 2); chk("R10 no issue", 32'(iss_valid), 0); end
          default: begin chk("R7 unsupported", 32'(st), 3); chk("R10 no issue", 32'(iss_valid), 0); end
        endcase
      end
      chk("R9 count", 32'(outstanding), 32'(e[2:0]));
    end

    // R6 stall counters, one per pairing
    chk("R6 st_ld", 32'(s_st_ld), 1);
    chk("R6 st_st", 32'(s_st_st), 1);
    chk("R6 ld_st", 32'(s_ld_st), 1);
    chk("R6 ld_ld", 32'(s_ld_ld), 1);

    // R11 completion and request in the same cycle at capacity
    @(negedge clk);
    cpl_valid = 1; cpl_write = 1; cpl_line = 16'h0300 >> OFFW;
    req_valid = 1; req_op = 2'd0; req_addr = 16'h0800;
    #1 chk("R11 status", 32'(req_status), 0);
    @(posedge clk); #1;
    req_valid = 0; cpl_valid = 0;
    chk("R11 count", 32'(outstanding), 4);
    chk("R11 issue", 32'(iss_valid), 1);

    step(2'd0, 2'd0, 4'b0000, 16'h0900, st);
    chk("R1 full at cap", 32'(st), 2);

    // R3 flush goes to the write table
    step(2'd1, 2'd0, 4'b0000, 16'h0400, st);
    step(2'd2, 2'd0, 4'b0000, 16'h0600, st);
    chk("R9 count after frees", 32'(outstanding), 2);
    step(2'd0, 2'd2, 4'b0000, 16'h0410, st);
    chk("R3 flush accept", 32'(st), 0);
    chk("R4 flush kind", 32'(iss_kind), 9);
    step(2'd0, 2'd0, 4'b0000, 16'h0430, st);
    chk("R3 flush aliased", 32'(st), 1);
    chk("R3 ld_st counter", 32'(s_ld_st), 2);
    step(2'd1, 2'd0, 4'b0000, 16'h0410, st);
    chk("R9 wrong-table completion", 32'(outstanding), 3);
    // R2 different line is independent
    step(2'd0, 2'd1, 4'b0000, 16'h0440, st);
    chk("R2 next line accept", 32'(st), 0);

    // R12 reset mid-run
    @(negedge clk); rst = 1;
    @(posedge clk); #1 rst = 0;
    chk("R12 count", 32'(outstanding), 0);
    chk("R12 stall", 32'(s_ld_st), 0);
    chk("R12 issue", 32'(iss_valid), 0);

    // R8 deadlock watchdog
    step(2'd0, 2'd0, 4'b0000, 16'h0955, st);
    chk("R8 accept", 32'(st), 0);
    repeat (TB_DL - 3) @(posedge clk);
    #1 chk("R8 not yet", 32'(dl_err), 0);
    repeat (5) @(posedge clk);
    #1 chk("R8 error", 32'(dl_err), 1);
    chk("R8 line", 32'(dl_line), 32'h0940);
    chk("R8 kind", 32'(dl_kind), 0);
    step(2'd1, 2'd0, 4'b0000, 16'h0940, st);
    chk("R8 sticky", 32'(dl_err), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule